// File: doc/BRIEF.md
# Reference Clock Output Divider

This block produces a reference clock for an output pin from one of two source clocks: the primary oscillator clock or the current system clock. A 16-bit control word sets four things:

- whether the output runs at all;
- which source is used;
- one of sixteen division ratios;
- whether the output stays alive while the device sleeps.

Both source clocks are sampled into a fast core clock domain. The output is rebuilt there from the sampled rising and falling edges of the selected source.

A second output asks the power controller to keep the primary oscillator on. It is raised when the enabled output uses the primary source and is set to run in sleep. In sleep, the output runs only when three conditions hold together: the primary source is selected, the run-in-sleep bit is set, and the device clock is in a primary oscillator mode. In every other sleep case the output is held low.

Changes to the ratio or to the source are held back until the next rising edge of the output. This prevents short pulses. When the source changes, the output stays high until the new source's first rising edge. Counting restarts from that edge.

Top module: `refclk_gen`

## Requirements
- R1: When control bit 15 (enable) is 0, `ref_out` is low from the next core clock cycle and shows no rising edge.
- R2: Control bit 12 selects the source: 1 selects `clk_prim`, 0 selects `clk_sys`.
- R3: Ratio code 0 (control bits 11:8) reproduces the selected source, with the same period and the same high time in core cycles.
- R4: Ratio code n, for 1 to 15, gives a period of 2^n source periods, with high and low phases of 2^(n-1) source periods each.
- R5: A new ratio code takes effect at the next rising edge of `ref_out`. The high and low phases already under way keep the old ratio.
- R6: A new source takes effect at the next rising edge of `ref_out`. The output then stays high until the first rising edge of the new source, and counts the new high phase from that edge. `ref_out` changes only after a sampled edge of a source, or after the output stops.
- R7: While `sleep` is 1, `ref_out` runs only if bit 12, bit 13 and `prim_mode` are all 1. Otherwise it is held low.
- R8: While `sleep` is 0, bit 13 and `prim_mode` have no effect on `ref_out`.
- R9: `osc_keep` is 1 one cycle after bits 15, 13 and 12 are all 1, and 0 one cycle after any of them is 0. It does not depend on `sleep` or `prim_mode`.
- R10: While reset is asserted, `ref_out` and `osc_keep` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; must be faster than twice either source frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_prim | input | 1 | Primary oscillator clock |
| clk_sys | input | 1 | Current system clock |
| sleep | input | 1 | Device is in the low-power sleep state |
| prim_mode | input | 1 | Device clock is in a primary oscillator mode |
| ctrl | input | 16 | Control word: bit 15 enable, bit 13 run in sleep, bit 12 source, bits 11:8 ratio |
| ref_out | output | 1 | Reference clock output |
| osc_keep | output | 1 | Request to keep the primary oscillator powered in sleep |

## Verification
The hardest case to reach is a source change that lands on an output rising edge while the new source is at an arbitrary phase. The stimulus creates it by rewriting the control word right after an observed rising edge. The two sources run at periods of 8 and 12 core cycles, so their relative phase at the commit point is not aligned. The mid-phase ratio change uses the same technique. The bench then measures the high and low widths of the next phases to confirm that the old phases complete and that no pulse is short. The sleep cases cover each combination of source, run-in-sleep bit and primary mode, with the output observed at the pin.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned DIV_W   = 4;
  localparam int unsigned NUM_SRC = 2;
  // control word field positions
  localparam int unsigned EN_POS  = 15;
  localparam int unsigned SLP_POS = 13;
  localparam int unsigned SEL_POS = 12;
  localparam int unsigned DIV_POS = 8;

  typedef enum logic {
    SRC_SYS  = 1'b0,
    SRC_PRIM = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic             enable;
    logic             run_in_sleep;
    src_sel_e         source;
    logic [DIV_W-1:0] ratio;
  } cfg_t;

  function automatic cfg_t decode_ctrl(input logic [CTRL_W-1:0] word);
    cfg_t c;
    c.enable       = word[EN_POS];
    c.run_in_sleep = word[SLP_POS];
    c.source       = src_sel_e'(word[SEL_POS]);
    c.ratio        = word[DIV_POS +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/refclk_rst_sync.sv
module refclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/refclk_src_sync.sv
module refclk_src_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              last_q;
  logic              lvl;

  assign lvl = pipe_q[STAGES-1];

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], src_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      last_q <= lvl;
    end
  end

  assign rise = lvl & ~last_q;
  assign fall = ~lvl & last_q;
endmodule

// File: rtl/refclk_policy.sv
module refclk_policy
  import refclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic sleep,
  input  logic prim_mode,
  output logic run,
  output logic keep
);
  logic sleep_ok;
  logic keep_d;
  logic keep_q;

  always_comb begin
    keep_d   = cfg.enable & (cfg.source == SRC_PRIM) & cfg.run_in_sleep;
    sleep_ok = keep_d & prim_mode;
    run      = cfg.enable & (~sleep | sleep_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
    end else begin
      keep_q <= keep_d;
    end
  end

  assign keep = keep_q;
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
  import refclk_pkg::*;
#(
  parameter int unsigned RATIO_W = DIV_W,
  parameter int unsigned SRC_N   = NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  src_sel_e           pend_src,
  input  logic [RATIO_W-1:0] pend_ratio,
  input  logic [SRC_N-1:0]   src_rise,
  input  logic [SRC_N-1:0]   src_fall,
  output logic               ref_out
);
  localparam int unsigned MAX_EXP = (1 << RATIO_W) - 1;
  localparam int unsigned CNT_W   = (MAX_EXP > 1) ? MAX_EXP - 1 : 1;
  localparam int unsigned HW      = CNT_W + 2;

  src_sel_e           src_q, src_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               out_q, out_d;
  logic               align_q, align_d;
  logic               sel_rise, sel_fall;
  logic               commit;
  logic [HW-1:0]      half_full;
  logic [CNT_W-1:0]   lim;

  assign sel_rise = src_rise[src_q];
  assign sel_fall = src_fall[src_q];

  // half period in source rising edges, minus one
  always_comb begin
    half_full = (HW'(1) << ratio_q) >> 1;
    lim       = CNT_W'(half_full - HW'(1));
  end

  always_comb begin
    out_d   = out_q;
    cnt_d   = cnt_q;
    src_d   = src_q;
    ratio_d = ratio_q;
    align_d = align_q;
    commit  = 1'b0;
    if (!run) begin
      out_d   = 1'b0;
      cnt_d   = '0;
      src_d   = pend_src;
      ratio_d = pend_ratio;
      align_d = 1'b0;
    end else if (align_q) begin
      if (sel_rise) begin
        align_d = 1'b0;
      end
    end else if (ratio_q == '0) begin
      if (sel_rise) begin
        out_d  = 1'b1;
        commit = ~out_q;
      end else if (sel_fall) begin
        out_d = 1'b0;
      end
    end else if (sel_rise) begin
      if (cnt_q == lim) begin
        cnt_d  = '0;
        out_d  = ~out_q;
        commit = ~out_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (commit) begin
      src_d   = pend_src;
      ratio_d = pend_ratio;
      cnt_d   = '0;
      align_d = (pend_src != src_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      cnt_q   <= '0;
      src_q   <= SRC_SYS;
      ratio_q <= '0;
      align_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      cnt_q   <= cnt_d;
      src_q   <= src_d;
      ratio_q <= ratio_d;
      align_q <= align_d;
    end
  end

  assign ref_out = out_q;
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_prim,
  input  logic              clk_sys,
  input  logic              sleep,
  input  logic              prim_mode,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              ref_out,
  output logic              osc_keep
);
  logic               rst_sync_n;
  cfg_t               cfg;
  logic               run;
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_rise;
  logic [NUM_SRC-1:0] src_fall;
  logic               src_edge_any;
  logic               unused_ctrl_bits;

  assign cfg              = decode_ctrl(ctrl);
  assign unused_ctrl_bits = ^{ctrl[14], ctrl[7:0]};
  assign src_raw          = {clk_prim, clk_sys};
  assign src_edge_any     = |(src_rise | src_fall);

  refclk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    refclk_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .src_in (src_raw[g]),
      .rise   (src_rise[g]),
      .fall   (src_fall[g])
    );
  end

  refclk_policy u_policy (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg       (cfg),
    .sleep     (sleep),
    .prim_mode (prim_mode),
    .run       (run),
    .keep      (osc_keep)
  );

  refclk_divider u_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .pend_src   (cfg.source),
    .pend_ratio (cfg.ratio),
    .src_rise   (src_rise),
    .src_fall   (src_fall),
    .ref_out    (ref_out)
  );
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [15:0] ctrl,
  input logic        sleep,
  input logic        prim_mode,
  input logic        ref_out,
  input logic        osc_keep,
  input logic        run,
  input logic        src_edge_any
);
  assert_disable_low_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl[15] |=> !ref_out);

  assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep && !(ctrl[12] && ctrl[13] && prim_mode)) |=> !ref_out);

  assert_keep_on_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl[15] && ctrl[13] && ctrl[12]) |=> osc_keep);

  assert_keep_off_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ctrl[15] && ctrl[13] && ctrl[12]) |=> !osc_keep);

  // R6: every output change follows a sampled source edge or a stop
  assert_edge_driven_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_out != $past(ref_out)) |-> ($past(src_edge_any) || !$past(run)));
endmodule

bind refclk_gen refclk_gen_chk u_chk (.*);

// File: tb/refclk_gen_tb.sv
module refclk_gen_tb;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic        sel;
    logic [3:0]  div;
    logic [15:0] per;
    logic [15:0] hi;
  } vec_t;

  // sys period 8 core cycles, prim period 12
  localparam vec_t VEC [8] = '{
    '{1'b0, 4'd0, 16'd8,   16'd4},
    '{1'b0, 4'd1, 16'd16,  16'd8},
    '{1'b0, 4'd3, 16'd64,  16'd32},
    '{1'b1, 4'd0, 16'd12,  16'd6},
    '{1'b1, 4'd2, 16'd48,  16'd24},
    '{1'b0, 4'd5, 16'd256, 16'd128},
    '{1'b1, 4'd4, 16'd192, 16'd96},
    '{1'b0, 4'd2, 16'd32,  16'd16}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_prim = 1'b0;
  logic        clk_sys = 1'b0;
  logic        sleep;
  logic        prim_mode;
  logic [15:0] ctrl;
  logic        ref_out;
  logic        osc_keep;

  int n_chk = 0;
  int n_fail = 0;
  int cs = 0;
  int cp = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (cs == 3) begin cs <= 0; clk_sys <= ~clk_sys; end
    else cs <= cs + 1;
    if (cp == 5) begin cp <= 0; clk_prim <= ~clk_prim; end
    else cp <= cp + 1;
  end

  refclk_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_prim  (clk_prim),
    .clk_sys   (clk_sys),
    .sleep     (sleep),
    .prim_mode (prim_mode),
    .ctrl      (ctrl),
    .ref_out   (ref_out),
    .osc_keep  (osc_keep)
  );

  function automatic logic [15:0] mk(bit en, bit slp, bit sel, int div);
    logic [15:0] w;
    w        = '0;
    w[15]    = en;
    w[13]    = slp;
    w[12]    = sel;
    w[11:8]  = div[3:0];
    return w;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    do begin
      p = ref_out;
      @(negedge clk);
    end while (!(!p && ref_out));
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (ref_out) begin hi++; @(negedge clk); end
    while (!ref_out) begin lo++; @(negedge clk); end
  endtask

  task automatic settled(output int hi, output int lo);
    wait_rise();
    measure(hi, lo);
    measure(hi, lo);
  endtask

  task automatic count_rises(int n, output int r);
    logic p;
    r = 0;
    p = ref_out;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!p && ref_out) r++;
      p = ref_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int h, l, r;
    rst_n     = 1'b0;
    sleep     = 1'b0;
    prim_mode = 1'b1;
    ctrl      = mk(1, 1, 1, 2);
    repeat (4) @(negedge clk);
    check(ref_out == 1'b0, "R10", "ref_out in reset", int'(ref_out), 0);
    check(osc_keep == 1'b0, "R10", "osc_keep in reset", int'(osc_keep), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(osc_keep == 1'b1, "R9", "keep with en/sel/slp", int'(osc_keep), 1);

    // table walk: R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      ctrl = mk(1, 0, VEC[i].sel, int'(VEC[i].div));
      settled(h, l);
      check(h + l == int'(VEC[i].per), (VEC[i].div == 0) ? "R2 R3" : "R2 R4",
            "period", h + l, int'(VEC[i].per));
      check(h == int'(VEC[i].hi), (VEC[i].div == 0) ? "R2 R3" : "R2 R4",
            "high time", h, int'(VEC[i].hi));
    end

    // R1: disabled output
    ctrl = mk(0, 1, 1, 2);
    repeat (2) @(negedge clk);
    check(ref_out == 1'b0, "R1", "ref_out disabled", int'(ref_out), 0);
    count_rises(300, r);
    check(r == 0, "R1", "rises while disabled", r, 0);
    check(osc_keep == 1'b0, "R9", "keep needs enable", int'(osc_keep), 0);

    // R5: ratio change mid high phase
    ctrl = mk(1, 0, 0, 3);
    settled(h, l);
    ctrl = mk(1, 0, 0, 1);
    measure(h, l);
    check(h == 32, "R5", "old high kept", h, 32);
    check(l == 32, "R5", "old low kept", l, 32);
    measure(h, l);
    check(h == 8 && l == 8, "R5", "new ratio high", h, 8);

    // R6: source change at output rise
    ctrl = mk(1, 0, 0, 2);
    settled(h, l);
    ctrl = mk(1, 0, 1, 2);
    measure(h, l);
    check(h == 16 && l == 16, "R6", "old source phase", h + l, 32);
    measure(h, l);
    check(h >= 25 && h <= 36, "R6", "realigned high", h, 25);
    check(l == 24, "R6", "first new low", l, 24);
    measure(h, l);
    check(h + l == 48, "R6", "new source period", h + l, 48);

    // R7: sleep gating
    sleep = 1'b1;
    ctrl  = mk(1, 1, 0, 2);
    repeat (2) @(negedge clk);
    count_rises(300, r);
    check(r == 0, "R7", "sleep with system source", r, 0);
    check(osc_keep == 1'b0, "R9", "keep with system source", int'(osc_keep), 0);
    ctrl = mk(1, 0, 1, 2);
    repeat (2) @(negedge clk);
    count_rises(300, r);
    check(r == 0, "R7", "sleep without run bit", r, 0);
    check(osc_keep == 1'b0, "R9", "keep without run bit", int'(osc_keep), 0);
    ctrl      = mk(1, 1, 1, 2);
    prim_mode = 1'b0;
    repeat (2) @(negedge clk);
    count_rises(300, r);
    check(r == 0, "R7", "sleep outside primary mode", r, 0);
    check(osc_keep == 1'b1, "R9", "keep ignores prim_mode", int'(osc_keep), 1);
    prim_mode = 1'b1;
    settled(h, l);
    check(h + l == 48 && h == 24, "R7", "runs in sleep", h + l, 48);

    // R8: awake, bit 13 and prim_mode do not matter
    sleep     = 1'b0;
    prim_mode = 1'b0;
    ctrl      = mk(1, 0, 1, 2);
    settled(h, l);
    check(h + l == 48 && h == 24, "R8", "awake primary", h + l, 48);
    ctrl = mk(1, 1, 0, 1);
    settled(h, l);
    check(h + l == 16 && h == 8, "R8", "awake system", h + l, 16);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule